// File: doc/BRIEF.md
# Sign-Magnitude Add/Subtract Unit

This block adds or subtracts two signed integers that are stored in sign-magnitude form. The top bit of each word is the sign and the rest is the absolute value. Internally the arithmetic is done in ones' complement. Each operand is mapped into that encoding as it enters the unit. A subtraction is made by inverting every bit of the second operand, so no separate subtractor is needed. The adder feeds its carry out of the top bit back into the bottom bit (end-around carry). The result is then mapped back to sign-magnitude.

Both encodings have two patterns for zero. The unit treats a negative-zero operand exactly like positive zero. It never emits a negative zero: any zero result leaves as all bits clear. A zero flag marks zero results, and an overflow flag marks results whose true value falls outside the representable range.

One register stage holds the result, the flags and a valid strobe. The register loads only on cycles where the input strobe is high.

Top module: `smag_addsub_unit`

## Requirements
- R1: Words are WIDTH bits wide. Bit WIDTH-1 is the sign (0 positive, 1 negative) and bits WIDTH-2..0 are the magnitude, giving a range of -(2^(WIDTH-1)-1) to +(2^(WIDTH-1)-1). With WIDTH=8, +43 is 8'h2B and -43 is 8'hAB.
- R2: When `op_sub`=0 and `in_valid`=1, the next clock loads `res_q` with the sign-magnitude encoding of a+b, provided that sum is in range.
- R3: When `op_sub`=1 and `in_valid`=1, the next clock loads `res_q` with the encoding of a-b, provided that difference is in range.
- R4: `ovf_q` is 1 exactly when the true sum or difference lies outside the range. When it is 1, the value of `res_q` is unspecified and `zero_q` is 0.
- R5: A negative-zero operand (sign 1, magnitude 0; 8'h80 for WIDTH=8) gives the same results and flags as positive zero.
- R6: A zero result is always output as all bits 0, never as negative zero. `zero_q` is 1 exactly when the loaded result is zero without overflow.
- R7: `out_valid` equals `in_valid` delayed by one clock. On a cycle where `in_valid`=0, `res_q`, `ovf_q` and `zero_q` keep their values whatever the operand and mode inputs do.
- R8: A synchronous reset (`rst`=1 at a rising edge) clears `res_q`, `ovf_q`, `zero_q` and `out_valid` to 0.
- R9: A carry out of the top bit of the ones' complement sum is added back into its least significant bit. For example, -1 + 3 gives +2 (8'h02).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_sub | input | 1 | 0 adds, 1 subtracts opnd_b from opnd_a |
| opnd_a | input | WIDTH | First operand, sign-magnitude |
| opnd_b | input | WIDTH | Second operand, sign-magnitude |
| res_q | output | WIDTH | Registered result, sign-magnitude |
| ovf_q | output | 1 | Registered overflow flag |
| zero_q | output | 1 | Registered zero flag |
| out_valid | output | 1 | Registered valid strobe |

## Verification
The bench targets the places where the two zero patterns meet:
- a negative-zero operand, which a design with a careless conversion would treat as minus the full range;
- opposite values that sum to all ones, which a design without normalisation would output as 8'h80 with the zero flag low.

It drives sums that need the end-around carry, where a plain binary adder would be off by one, and results one step past the range limit, where a wrong overflow rule would wrap silently. It also drives every operand pair in both modes against an integer model. Finally, it changes the operands while the strobe is low, to catch a register that loads without its enable.

// File: rtl/smag_pkg.sv
package smag_pkg;

   // Implementation variant of the end-around-carry adder
   typedef enum logic [0:0] {
      ADDER_BEHAV  = 1'b0,
      ADDER_RIPPLE = 1'b1
   } adder_style_e;

   // Arithmetic mode as seen by the datapath
   typedef enum logic [0:0] {
      MODE_ADD = 1'b0,
      MODE_SUB = 1'b1
   } arith_mode_e;

endpackage

// File: rtl/smag_to_oc.sv
// Sign-magnitude to ones' complement converter with optional full inversion
// (the inversion turns an operand into its negation for subtraction).
module smag_to_oc #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] sm_in,
   input  logic             negate,
   output logic [WIDTH-1:0] oc_out
);
   localparam int MAG_W = WIDTH - 1;

   logic             sgn;
   logic [MAG_W-1:0] mag;
   logic [WIDTH-1:0] oc_plain;

   assign sgn      = sm_in[WIDTH-1];
   assign mag      = sm_in[MAG_W-1:0];
   // negative values carry an inverted magnitude; the sign bit is unchanged
   assign oc_plain = {sgn, mag ^ {MAG_W{sgn}}};
   assign oc_out   = oc_plain ^ {WIDTH{negate}};

endmodule

// File: rtl/oc_eac_adder.sv
// Ones' complement adder: binary sum, then the carry out of the top bit is
// wrapped back into the least significant bit.
module oc_eac_adder
   import smag_pkg::*;
#(
   parameter int           WIDTH = 8,
   parameter adder_style_e STYLE = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             wrap_carry
);
   localparam int XW = WIDTH + 1;

   generate
      if (STYLE == ADDER_BEHAV) begin : g_behav
         logic [XW-1:0]    first_pass;
         logic [WIDTH-1:0] wrap_vec;

         assign first_pass = {1'b0, x_in} + {1'b0, y_in};
         assign wrap_vec   = {{(WIDTH-1){1'b0}}, first_pass[WIDTH]};
         assign sum_out    = first_pass[WIDTH-1:0] + wrap_vec;
         assign wrap_carry = first_pass[WIDTH];
      end else begin : g_ripple
         logic [WIDTH:0]   cy;
         logic [WIDTH-1:0] raw;
         logic [WIDTH-1:0] inc_cy;

         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            assign raw[i]  = x_in[i] ^ y_in[i] ^ cy[i];
            assign cy[i+1] = (x_in[i] & y_in[i]) | (cy[i] & (x_in[i] ^ y_in[i]));
         end

         // second pass: incrementer fed by the wrapped carry; it cannot
         // overflow because the first pass never leaves all ones with a carry
         assign inc_cy[0] = cy[WIDTH];
         for (genvar j = 0; j < WIDTH; j++) begin : g_ha
            assign sum_out[j] = raw[j] ^ inc_cy[j];
            if (j < WIDTH - 1) begin : g_next
               assign inc_cy[j+1] = raw[j] & inc_cy[j];
            end
         end
         assign wrap_carry = cy[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/oc_to_smag.sv
// Ones' complement to sign-magnitude converter. Both zero patterns are
// detected and leave as positive zero.
module oc_to_smag #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] oc_in,
   output logic [WIDTH-1:0] sm_out,
   output logic             is_zero
);
   localparam int MAG_W = WIDTH - 1;

   logic             sgn;
   logic [MAG_W-1:0] mag;
   logic             pos_zero;
   logic             neg_zero;

   assign sgn      = oc_in[WIDTH-1];
   assign mag      = oc_in[MAG_W-1:0] ^ {MAG_W{sgn}};
   assign pos_zero = (oc_in == {WIDTH{1'b0}});
   assign neg_zero = (oc_in == {WIDTH{1'b1}});
   assign is_zero  = pos_zero | neg_zero;

   always_comb begin
      if (is_zero) begin
         sm_out = '0;
      end else begin
         sm_out = {sgn, mag};
      end
   end

endmodule

// File: rtl/smag_addsub_unit.sv
// Registered sign-magnitude add/subtract with a ones' complement core.
module smag_addsub_unit
   import smag_pkg::*;
#(
   parameter int           WIDTH       = 8,
   parameter adder_style_e ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             op_sub,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] res_q,
   output logic             ovf_q,
   output logic             zero_q,
   output logic             out_valid
);
   localparam int SGN = WIDTH - 1;

   // elaboration-time parameter check
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("smag_addsub_unit: WIDTH must be at least 2");
      end
   endgenerate

   arith_mode_e      mode;
   logic [WIDTH-1:0] a_oc;
   logic [WIDTH-1:0] b_oc;
   logic [WIDTH-1:0] s_oc;
   logic             s_wrap;
   logic [WIDTH-1:0] s_sm;
   logic             s_zero;
   logic             s_ovf;

   assign mode = op_sub ? MODE_SUB : MODE_ADD;

   smag_to_oc #(.WIDTH(WIDTH)) u_conv_a (
      .sm_in  (opnd_a),
      .negate (1'b0),
      .oc_out (a_oc)
   );

   smag_to_oc #(.WIDTH(WIDTH)) u_conv_b (
      .sm_in  (opnd_b),
      .negate (mode == MODE_SUB),
      .oc_out (b_oc)
   );

   oc_eac_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .x_in       (a_oc),
      .y_in       (b_oc),
      .sum_out    (s_oc),
      .wrap_carry (s_wrap)
   );

   oc_to_smag #(.WIDTH(WIDTH)) u_conv_r (
      .oc_in   (s_oc),
      .sm_out  (s_sm),
      .is_zero (s_zero)
   );

   // same-sign operands with an opposite-sign sum overflowed the range
   assign s_ovf = (a_oc[SGN] == b_oc[SGN]) && (s_oc[SGN] != a_oc[SGN]);

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q     <= '0;
         ovf_q     <= 1'b0;
         zero_q    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_q  <= s_sm;
            ovf_q  <= s_ovf;
            zero_q <= s_zero & ~s_ovf;
         end
      end
   end

   logic unused_wrap;
   assign unused_wrap = s_wrap;

endmodule

// File: rtl/smag_addsub_chk.sv
// Property checker for smag_addsub_unit, attached by bind.
module smag_addsub_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [WIDTH-1:0] res_q,
   input logic             ovf_q,
   input logic             zero_q,
   input logic             out_valid
);
   localparam logic [WIDTH-1:0] NEG_ZERO = {1'b1, {(WIDTH-1){1'b0}}};

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R7
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(res_q) && $stable(ovf_q) && $stable(zero_q)));

   // R6
   no_neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
      res_q != NEG_ZERO);

   // R6
   zero_value_chk: assert property (@(posedge clk) disable iff (rst)
      zero_q |-> (res_q == '0));

   // R4
   ovf_not_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_q |-> !zero_q);

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !ovf_q && !zero_q && res_q == '0));

endmodule

bind smag_addsub_unit smag_addsub_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .res_q     (res_q),
   .ovf_q     (ovf_q),
   .zero_q    (zero_q),
   .out_valid (out_valid)
);

// File: tb/smag_addsub_unit_bench.sv
`timescale 1ns/1ps
module smag_addsub_unit_bench;
   localparam int W   = 8;
   localparam int MAX = 127;
   localparam int NV  = 15;
   localparam int WATCHDOG = 190000;

   // vector: {op, a, b, exp_res, exp_ovf, exp_zero}
   localparam logic [26:0] VEC [NV] = '{
      {1'b0, 8'h2B, 8'h00, 8'h2B, 1'b0, 1'b0},  // R1 +43
      {1'b0, 8'hAB, 8'h00, 8'hAB, 1'b0, 1'b0},  // R1 -43
      {1'b0, 8'h2B, 8'hAB, 8'h00, 1'b0, 1'b1},  // R6 opposite values
      {1'b1, 8'h2B, 8'h2B, 8'h00, 1'b0, 1'b1},  // R6 self difference
      {1'b0, 8'h81, 8'h03, 8'h02, 1'b0, 1'b0},  // R9 end-around carry
      {1'b1, 8'h05, 8'h07, 8'h82, 1'b0, 1'b0},  // R3 negative result
      {1'b0, 8'h7F, 8'h01, 8'h00, 1'b1, 1'b0},  // R4 positive overflow
      {1'b1, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},  // R4 negative overflow
      {1'b0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1},  // R5 -0 + -0
      {1'b1, 8'h80, 8'h00, 8'h00, 1'b0, 1'b1},  // R5 -0 - +0
      {1'b0, 8'h80, 8'h2B, 8'h2B, 1'b0, 1'b0},  // R5 -0 + 43
      {1'b1, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1},  // R5 +0 - -0
      {1'b0, 8'h7F, 8'hFF, 8'h00, 1'b0, 1'b1},  // R6 max + min
      {1'b1, 8'hAB, 8'hD6, 8'h2B, 1'b0, 1'b0},  // R3 -43 - -86
      {1'b0, 8'h7E, 8'h01, 8'h7F, 1'b0, 1'b0}   // R4 edge, no overflow
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         op_sub = 1'b0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] res_q;
   logic         ovf_q;
   logic         zero_q;
   logic         out_valid;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   smag_addsub_unit #(.WIDTH(W)) u_smag_addsub_unit (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .op_sub    (op_sub),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .res_q     (res_q),
      .ovf_q     (ovf_q),
      .zero_q    (zero_q),
      .out_valid (out_valid)
   );

   function automatic int sm_val(input logic [W-1:0] v);
      int m;
      m = int'(v[W-2:0]);
      return v[W-1] ? -m : m;
   endfunction

   function automatic logic [W-1:0] sm_enc(input int v);
      logic [W-1:0] r;
      if (v < 0) r = {1'b1, 7'(-v)};
      else       r = {1'b0, 7'(v)};
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] got_r,
                        input logic got_o, input logic got_z,
                        input logic [W-1:0] exp_r, input logic exp_o,
                        input logic exp_z);
      checks++;
      if (got_o !== exp_o || (!exp_o && (got_r !== exp_r || got_z !== exp_z))
          || (exp_o && got_z !== 1'b0)) begin
         errors++;
         $display("FAIL %s res=%h ovf=%b zero=%b expected res=%h ovf=%b zero=%b",
                  req, got_r, got_o, got_z, exp_r, exp_o, exp_z);
      end
   endtask

   // drives one operation (away from the edge) and samples 1 ns after the
   // edge that loads it
   task automatic run_op(input logic op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
      in_valid = 1'b1;
      op_sub   = op;
      opnd_a   = a;
      opnd_b   = b;
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int r;
      logic [W-1:0] er;
      logic eo;
      logic ez;

      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      checks++;
      if (res_q !== '0 || ovf_q !== 1'b0 || zero_q !== 1'b0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R8 reset res=%h ovf=%b zero=%b vld=%b expected all 0",
                  res_q, ovf_q, zero_q, out_valid);
      end
      rst = 1'b0;

      // directed vector table
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
         check($sformatf("R1-table[%0d]", i), res_q, ovf_q, zero_q,
               VEC[i][9:2], VEC[i][1], VEC[i][0]);
      end

      // R7 valid strobe follows input
      checks++;
      if (out_valid !== 1'b1) begin
         errors++;
         $display("FAIL R7 out_valid=%b expected 1", out_valid);
      end

      // R7 hold while in_valid low: known value then changing inputs
      run_op(1'b0, 8'h2B, 8'h01);
      in_valid = 1'b0;
      op_sub   = 1'b1;
      opnd_a   = 8'hFF;
      opnd_b   = 8'h7F;
      @(posedge clk);
      #1;
      checks++;
      if (res_q !== 8'h2C || ovf_q !== 1'b0 || zero_q !== 1'b0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R7 hold res=%h ovf=%b zero=%b vld=%b expected 2c 0 0 0",
                  res_q, ovf_q, zero_q, out_valid);
      end
      opnd_a = 8'h80;
      opnd_b = 8'h80;
      @(posedge clk);
      #1;
      checks++;
      if (res_q !== 8'h2C || zero_q !== 1'b0) begin
         errors++;
         $display("FAIL R7 hold2 res=%h zero=%b expected 2c 0", res_q, zero_q);
      end

      // exhaustive pairs, both modes, against integer model (R2 R3 R4 R5 R6)
      for (int op = 0; op < 2; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               r  = (op == 1) ? sm_val(8'(a)) - sm_val(8'(b))
                              : sm_val(8'(a)) + sm_val(8'(b));
               eo = (r > MAX) || (r < -MAX);
               er = eo ? '0 : sm_enc(r);
               ez = !eo && (r == 0);
               run_op(op[0], 8'(a), 8'(b));
               check(op == 1 ? "R3 exhaustive" : "R2 exhaustive",
                     res_q, ovf_q, zero_q, er, eo, ez);
            end
         end
      end

      // R8 reset in mid-run clears a nonzero result
      run_op(1'b0, 8'hAB, 8'h81);
      in_valid = 1'b0;
      rst      = 1'b1;
      @(posedge clk);
      #1;
      checks++;
      if (res_q !== '0 || ovf_q !== 1'b0 || zero_q !== 1'b0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R8 mid-run reset res=%h ovf=%b zero=%b vld=%b expected all 0",
                  res_q, ovf_q, zero_q, out_valid);
      end
      rst = 1'b0;
      @(posedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule